// File: doc/BRIEF.md
# Asynchronous Expansion Bus Phase Controller

This block runs single read and write accesses on an external asynchronous parallel bus. The bus has an address, an active-low chip select, active-low read and write strobes and a data bus split into output, output-enable and input lanes. Every access passes through four timed phases: address setup, address hold, data strobe and recovery. The length of each phase comes from its own timing input.

A slow peripheral may hold an active-low wait line to stretch the data strobe phase. The wait line goes through a two-flop synchronizer. The strobe phase is therefore never shorter than the synchronizer can observe, even when the hold and strobe counts are both zero. The phase ends on the cycle after the synchronized wait is released; the strobe count is not restarted. A wait held too long ends the access with an error.

The host places a request and holds it until a one-cycle acknowledge. The acknowledge comes with the read data and the error flag.

Top module: `xbus_phase_ctrl`

## Requirements
- R1: After reset the chip select, read strobe and write strobe are high, the data output enable is low and the acknowledge is low.
- R2: With setup count S, hold count H and recovery count R, the setup phase lasts S+1 cycles, the hold phase H+1 and the recovery phase R+1. Chip select stays low for S+H+R+3 cycles plus the strobe phase length.
- R3: With strobe count C and no wait, the strobe phase lasts max(C+1, 3) cycles, where 3 is the synchronizer depth plus one. This holds also when C is 0.
- R4: If the wait input (0 = wait) falls in the first strobe cycle, the strobe phase is stretched, even with all counts at zero.
- R5: If wait is held low for W cycles (W >= 1) from the first strobe cycle, the strobe phase lasts max(C+1, 3, W+3) cycles. The phase ends two synchronizer cycles plus one after the release, not after a new count.
- R6: During a read the data output enable stays low for the whole access. The data bus value from the last strobe cycle is returned with the acknowledge.
- R7: During a write the data output enable is high from the first setup cycle to the last recovery cycle. The write strobe is low only in the strobe phase.
- R8: If the synchronized wait is still asserted after the strobe phase has spent WAIT_LIMIT-1 cycles past its minimum length, the access moves to recovery and the acknowledge carries error = 1. The strobe phase then lasts max(C+1, 3) + WAIT_LIMIT - 1 cycles. The error is cleared by the next request.
- R9: The acknowledge is high for exactly one cycle, in the cycle after recovery ends. A new request is taken only when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request, held until acknowledge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqAck | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Captured read data |
| rspErr | output | 1 | Wait timeout flag for the finished access |
| cfgSetup | input | CNT_W | Address setup count |
| cfgHold | input | CNT_W | Address hold count |
| cfgStrobe | input | CNT_W | Data strobe count |
| cfgRecover | input | CNT_W | Recovery count |
| busAddr | output | ADDR_W | Bus address |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busDataOut | output | DATA_W | Write data to the bus |
| busDataOe | output | 1 | Data output enable |
| busDataIn | input | DATA_W | Read data from the bus |
| busWaitN | input | 1 | Peripheral wait, active low |

## Verification
The assertions check the following on every cycle:
- the strobe phase never ends before the synchronizer minimum;
- a synchronized wait keeps the controller in the strobe phase until the timeout;
- a released wait with an expired count moves it to recovery on the next cycle;
- the data bus is never driven during a read;
- the acknowledge is a single pulse.

The exact cycle counts can only be shown by the bench scenarios. These are the phase lengths for various programmed counts, the stretch length for several wait widths against short and long strobe counts, and the timeout length with its error flag. The scenarios also show read data returning from the last strobe cycle and write data reaching the peripheral.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HOLD, PH_STROBE, PH_RECOVER, PH_DONE
  } xbusPhase_e;

  typedef struct packed {
    logic load;     // accept host request
    logic active;   // inside setup..recovery
    logic strobe;   // data strobe phase
    logic capture;  // last strobe cycle
    logic setErr;   // leaving strobe on timeout
  } xbusCtl_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_LIMIT  = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic             waitSync,
  output xbusCtl_t         ctl,
  output logic             reqAck
);
  localparam int MIN_T3 = SYNC_STAGES + 1;
  localparam int PH_W   = CNT_W + $clog2(MIN_T3 + 1);
  localparam int TMR_W  = $clog2(WAIT_LIMIT);

  xbusPhase_e        state, nextState;
  logic [PH_W-1:0]   phaseCnt, phaseLimit, strobeLimit;
  logic [TMR_W-1:0]  waitTimer;
  logic              cntDone, timerEnd, waiting;

  always_comb begin
    strobeLimit = (PH_W'(cfgStrobe) > PH_W'(MIN_T3 - 1)) ? PH_W'(cfgStrobe)
                                                         : PH_W'(MIN_T3 - 1);
    case (state)
      PH_SETUP:   phaseLimit = PH_W'(cfgSetup);
      PH_HOLD:    phaseLimit = PH_W'(cfgHold);
      PH_STROBE:  phaseLimit = strobeLimit;
      PH_RECOVER: phaseLimit = PH_W'(cfgRecover);
      default:    phaseLimit = '0;
    endcase
  end

  assign cntDone  = (phaseCnt >= phaseLimit);
  assign timerEnd = (waitTimer == TMR_W'(WAIT_LIMIT - 1));
  assign waiting  = (state == PH_STROBE) && cntDone && waitSync;

  always_comb begin
    nextState = state;
    case (state)
      PH_IDLE:    if (reqValid) nextState = PH_SETUP;
      PH_SETUP:   if (cntDone) nextState = PH_HOLD;
      PH_HOLD:    if (cntDone) nextState = PH_STROBE;
      PH_STROBE:  if (cntDone && (!waitSync || timerEnd)) nextState = PH_RECOVER;
      PH_RECOVER: if (cntDone) nextState = PH_DONE;
      PH_DONE:    nextState = PH_IDLE;
      default:    nextState = PH_IDLE;
    endcase
  end

  always_comb begin
    ctl.load    = (state == PH_IDLE) && reqValid;
    ctl.active  = (state == PH_SETUP) || (state == PH_HOLD) ||
                  (state == PH_STROBE) || (state == PH_RECOVER);
    ctl.strobe  = (state == PH_STROBE);
    ctl.capture = (state == PH_STROBE) && (nextState == PH_RECOVER);
    ctl.setErr  = ctl.capture && waitSync;
  end

  assign reqAck = (state == PH_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      phaseCnt  <= '0;
      waitTimer <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) phaseCnt <= '0;
      else if (!cntDone)      phaseCnt <= phaseCnt + 1'b1;
      if (waiting && !timerEnd) waitTimer <= waitTimer + 1'b1;
      else if (!waiting)        waitTimer <= '0;
    end
  end

  AST_T3_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_STROBE && nextState == PH_RECOVER) |-> (phaseCnt >= PH_W'(MIN_T3 - 1))) // R3
    else $error("strobe phase left before synchronizer minimum");
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_STROBE && waitSync && !timerEnd) |=> (state == PH_STROBE)) // R4
    else $error("wait did not hold strobe phase");
  AST_WAIT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_STROBE && cntDone && !waitSync) |=> (state == PH_RECOVER)) // R5
    else $error("released wait did not end strobe phase");
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck) // R9
    else $error("acknowledge longer than one cycle");
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  xbusCtl_t          ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busWaitN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              waitSync
);
  logic                   isWrite;
  logic [SYNC_STAGES-1:0] waitPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) waitPipe <= '1;
    else       waitPipe <= {waitPipe[SYNC_STAGES-2:0], busWaitN};
  end
  assign waitSync = !waitPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite    <= 1'b0;
      busAddr    <= '0;
      busDataOut <= '0;
      rspRdata   <= '0;
      rspErr     <= 1'b0;
    end else begin
      if (ctl.load) begin
        isWrite    <= reqWrite;
        busAddr    <= reqAddr;
        busDataOut <= reqWdata;
        rspErr     <= 1'b0;
      end
      if (ctl.capture && !isWrite) rspRdata <= busDataIn;
      if (ctl.setErr)              rspErr   <= 1'b1;
    end
  end

  assign busCsN    = !ctl.active;
  assign busRdN    = !(ctl.strobe && !isWrite);
  assign busWrN    = !(ctl.strobe && isWrite);
  assign busDataOe = ctl.active && isWrite;

  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busDataOe) // R6
    else $error("data bus driven during read strobe");
  AST_WR_DATA_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> (busDataOe && !busCsN)) // R7
    else $error("write strobe without driven data");
endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_LIMIT  = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgStrobe,
  input  logic [CNT_W-1:0]  cfgRecover,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busCsN,
  output logic              busRdN,
  output logic              busWrN,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busWaitN
);
  xbusCtl_t ctl;
  logic     waitSync;

  xbus_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .WAIT_LIMIT(WAIT_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .cfgSetup(cfgSetup), .cfgHold(cfgHold), .cfgStrobe(cfgStrobe), .cfgRecover(cfgRecover),
    .waitSync(waitSync), .ctl(ctl), .reqAck(reqAck)
  );

  xbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busDataIn(busDataIn), .busWaitN(busWaitN),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busCsN(busCsN), .busRdN(busRdN), .busWrN(busWrN),
    .rspRdata(rspRdata), .rspErr(rspErr), .waitSync(waitSync)
  );
endmodule

// File: tb/xbus_phase_ctrl_tb.sv
`timescale 1ns/100ps
module xbus_phase_ctrl_tb;
  localparam int AW = 16, DW = 16, CW = 4, LIM = 256;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqAck, rspErr;
  logic [DW-1:0] rspRdata;
  logic [CW-1:0] cfgSetup = '0, cfgHold = '0, cfgStrobe = '0, cfgRecover = '0;
  logic [AW-1:0] busAddr;
  logic busCsN, busRdN, busWrN, busDataOe;
  logic [DW-1:0] busDataOut, busDataIn;
  logic busWaitN = 1'b1;

  always #2.5 clk = ~clk;

  xbus_phase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .WAIT_LIMIT(LIM)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqAck(reqAck), .rspRdata(rspRdata),
    .rspErr(rspErr), .cfgSetup(cfgSetup), .cfgHold(cfgHold), .cfgStrobe(cfgStrobe),
    .cfgRecover(cfgRecover), .busAddr(busAddr), .busCsN(busCsN), .busRdN(busRdN),
    .busWrN(busWrN), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .busWaitN(busWaitN)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // peripheral model: small memory plus wait generator
  logic [DW-1:0] mem [16];
  assign busDataIn = mem[busAddr[3:0]];
  always @(posedge clk) if (!busWrN) mem[busAddr[3:0]] <= busDataOut;

  int waitCycles = 0, waitLeft = 0;
  logic prevStrobe = 1'b0;
  always @(negedge clk) begin
    if ((!busRdN || !busWrN) && !prevStrobe) waitLeft = waitCycles;
    prevStrobe = !busRdN || !busWrN;
    if (waitLeft > 0) begin busWaitN = 1'b0; waitLeft--; end
    else busWaitN = 1'b1;
  end

  typedef struct {
    bit wr; logic [DW-1:0] data; bit err; int cs; int st;
  } expItem_t;
  expItem_t expQ[$];

  // monitor
  int csCnt = 0, stCnt = 0, dirErr = 0;
  bit curWrite = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!busCsN) begin
        csCnt++;
        if (busDataOe !== curWrite) dirErr++;
      end
      if (!busRdN || !busWrN) stCnt++;
      if (reqAck) begin
        if (expQ.size() == 0) check(0, "R9 unexpected ack", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          check(csCnt == e.cs, "R2 chip select length", csCnt, e.cs);
          check(stCnt == e.st, "R3/R4/R5/R8 strobe length", stCnt, e.st);
          check(rspErr == e.err, "R8 error flag", int'(rspErr), int'(e.err));
          check(dirErr == 0, e.wr ? "R7 write drive window" : "R6 read bus released", dirErr, 0);
          if (!e.wr && !e.err) check(rspRdata == e.data, "R6 read data", rspRdata, e.data);
        end
        csCnt = 0; stCnt = 0; dirErr = 0;
      end
    end
  end

  task automatic access(input bit wr, input logic [3:0] a, input logic [DW-1:0] d,
                        input int s, input int h, input int c, input int r, input int w);
    expItem_t e;
    int minT3, t3;
    minT3 = (c + 1 > 3) ? c + 1 : 3;
    e.err = (w + 3 > minT3 + LIM - 1);
    if (e.err)      t3 = minT3 + LIM - 1;
    else if (w > 0) t3 = (w + 3 > minT3) ? w + 3 : minT3;
    else            t3 = minT3;
    e.wr = wr; e.data = d; e.st = t3; e.cs = s + h + r + 3 + t3;
    expQ.push_back(e);
    @(negedge clk);
    cfgSetup = CW'(s); cfgHold = CW'(h); cfgStrobe = CW'(c); cfgRecover = CW'(r);
    waitCycles = w; curWrite = wr;
    reqWrite = wr; reqAddr = AW'(a); reqWdata = d; reqValid = 1'b1;
    do @(negedge clk); while (!reqAck);
    reqValid = 1'b0;
    @(negedge clk);
    check(!reqAck, "R9 ack single cycle", int'(reqAck), 0);
    repeat (4) @(negedge clk);
    while (!busWaitN || waitLeft > 0) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = DW'(i * 16'h0101);
    repeat (5) @(negedge clk);
    check(busCsN && busRdN && busWrN, "R1 bus strobes idle", {busCsN, busRdN, busWrN}, 7);
    check(!busDataOe, "R1 output enable low", int'(busDataOe), 0);
    check(!reqAck, "R1 ack low", int'(reqAck), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busCsN, "R9 no access without request", int'(busCsN), 1);
    // zero counts, no wait: minimum strobe (R3)
    access(1, 4'd3, 16'hA5A5, 0, 0, 0, 0, 0);
    access(0, 4'd3, 16'hA5A5, 0, 0, 0, 0, 0);
    // varied phase counts (R2, R7)
    access(1, 4'd7, 16'h1234, 2, 1, 5, 3, 0);
    access(0, 4'd7, 16'h1234, 3, 2, 1, 4, 0);
    // zero counts stretched by wait (R4, R5)
    access(0, 4'd3, 16'hA5A5, 0, 0, 0, 0, 1);
    access(0, 4'd5, 16'h0505, 0, 0, 0, 0, 4);
    // long strobe count hides a short wait (R5)
    access(0, 4'd9, 16'h0909, 1, 0, 9, 0, 3);
    // long wait on a write, then read back (R5, R7)
    access(1, 4'd12, 16'hBEEF, 1, 1, 1, 1, 10);
    access(0, 4'd12, 16'hBEEF, 0, 1, 2, 0, 0);
    // wait timeout (R8), then error cleared by next access
    access(0, 4'd2, 16'h0202, 0, 0, 0, 0, 300);
    access(0, 4'd2, 16'h0202, 0, 0, 0, 0, 2);
    check(expQ.size() == 0, "R9 every request acknowledged", expQ.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule